// File: doc/BRIEF.md
# Flow-Controlled Serial Bitstream Player

This block plays a compressed audio bitstream into the serial input of an external decoder. The stream is stored as bytes in a ROM with combinational read. The block drives the ROM address, sends each byte one bit at a time on a data line, and generates a matching bit clock. The user controls transport with two buttons. Play starts the stream. Pressing play again pauses it, and a further press resumes from the same bit. Stop halts the stream and rewinds it to the first byte.

The decoder provides backpressure through a data-request input. When that input drops, the bit clock freezes and stays at its current level, and no bit is skipped. When the request comes back, streaming resumes at the same point. After the final ROM byte has gone out, the player returns to idle and rewinds. Two status outputs report whether the stream is running or paused.

Top module: `bitstream_feeder`

## Requirements
- R1: During reset and right after it, `sclk`, `sdata`, `playing` and `paused` are low and `rom_addr` is 0.
- R2: In idle, a play press makes `playing` high on the next clock edge. `playing` is high while streaming or while held back by `data_req`. `paused` is high only while paused. The two are never high together.
- R3: Each byte goes out MSB first, one bit per `sclk` period. `sclk` toggles at most once per system clock. `sdata` changes only while `sclk` is low.
- R4: While streaming and `data_req` is low, `sclk` and `rom_addr` hold, `playing` stays high, and no bit is lost or repeated when the request returns.
- R5: A play press while streaming pauses the stream. While paused, `sclk` and `rom_addr` hold. The next play press resumes from the exact bit where the stream stopped.
- R6: A stop press while streaming, held back or paused drives `playing`, `paused`, `sclk` and `rom_addr` to low/0 on the next edge. The next play starts again from byte 0.
- R7: Each button acts only on its rising level. Holding it high for many cycles has the effect of a single press.
- R8: When play and stop rise in the same cycle, stop wins. From a running stream the player stops and rewinds. From idle it stays idle.
- R9: After the last byte (address DEPTH-1) has been fully sent, the player goes idle and `rom_addr` returns to 0.
- R10: `rom_addr` changes only to its previous value plus one, after the eighth falling edge of `sclk` for the current byte, or to 0. Every address 0..DEPTH-1 is sent once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| play_btn | input | 1 | Play/pause button level |
| stop_btn | input | 1 | Stop button level |
| data_req | input | 1 | Decoder ready for more bits |
| rom_data | input | 8 | Byte read from ROM at `rom_addr` |
| rom_addr | output | ADDR_W | ROM byte address |
| sdata | output | 1 | Serial data to the decoder |
| sclk | output | 1 | Serial bit clock; the decoder samples on the rising edge |
| playing | output | 1 | Stream running or held back by the decoder |
| paused | output | 1 | Stream paused by the user |

## Verification
Three events can land on the same clock edge: a user transport event (play, stop, or both pressed together), a change in decoder backpressure, and the end of a byte or of the stream. The bench drives `data_req` at random while it presses buttons at arbitrary points. It also makes one directed simultaneous press of play and stop, both while streaming and while idle. A monitor rebuilds bytes from `sdata` at each rising edge of `sclk` and compares each one with the ROM byte expected next in order. Any lost, repeated or mis-ordered bit therefore shows up as a byte mismatch. Transport status and address are checked at the ports on the cycle after each press.

// File: rtl/bitstream_feeder.sv
module bitstream_feeder #(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              play_btn,
  input  logic              stop_btn,
  input  logic              data_req,
  input  logic [7:0]        rom_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              sdata,
  output logic              sclk,
  output logic              playing,
  output logic              paused
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_PLAY, S_WAIT, S_PAUSE, S_STOP} state_t;

  state_t      state, state_nx;
  logic        play_q, stop_q;
  logic        phase;
  logic [2:0]  bit_idx;
  logic [ADDR_W-1:0] addr;

  wire play_p = play_btn & ~play_q;
  wire stop_p = stop_btn & ~stop_q;
  wire live   = (state == S_PLAY) || (state == S_WAIT) || (state == S_PAUSE);
  wire en     = (state == S_PLAY) & data_req & ~stop_p & ~play_p;
  wire byte_end = en & phase & (bit_idx == 3'd7);
  wire last_end = byte_end & (addr == LAST);

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE, S_STOP: state_nx = (play_p && !stop_p) ? S_PLAY : S_IDLE;
      S_PLAY: begin
        if (stop_p)         state_nx = S_STOP;
        else if (play_p)    state_nx = S_PAUSE;
        else if (last_end)  state_nx = S_IDLE;
        else if (!data_req) state_nx = S_WAIT;
      end
      S_WAIT: begin
        if (stop_p)        state_nx = S_STOP;
        else if (play_p)   state_nx = S_PAUSE;
        else if (data_req) state_nx = S_PLAY;
      end
      S_PAUSE: begin
        if (stop_p)      state_nx = S_STOP;
        else if (play_p) state_nx = S_PLAY;
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      play_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      state  <= state_nx;
      play_q <= play_btn;
      stop_q <= stop_btn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (stop_p && live)) begin
      phase   <= 1'b0;
      bit_idx <= 3'd0;
      addr    <= '0;
    end else if (en) begin
      phase <= ~phase;
      if (phase) begin
        bit_idx <= bit_idx + 3'd1;
        if (bit_idx == 3'd7)
          addr <= (addr == LAST) ? '0 : addr + ADDR_W'(1);
      end
    end
  end

  assign rom_addr = addr;
  assign sclk     = phase;
  assign sdata    = live & rom_data[~bit_idx];
  assign playing  = (state == S_PLAY) || (state == S_WAIT);
  assign paused   = (state == S_PAUSE);

endmodule

// File: rtl/bitstream_feeder_checks.sv
module bitstream_feeder_checks #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              play_btn,
  input logic              stop_btn,
  input logic              data_req,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              sdata,
  input logic              sclk,
  input logic              playing,
  input logic              paused
);

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (rom_addr == '0) && !sclk && !playing && !paused);

  a_r2_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(playing && paused));

  a_r3_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));

  a_r4_backpressure_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && !data_req && !stop_btn) |=> $stable(sclk) && $stable(rom_addr));

  a_r5_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && $past(paused)) |-> $stable(sclk) && $stable(rom_addr));

  a_r6_stop_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_btn && !$past(stop_btn) && (playing || paused))
      |=> (rom_addr == '0) && !sclk && !playing && !paused);

  a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_addr != $past(rom_addr))
      |-> (rom_addr == $past(rom_addr) + ADDR_W'(1)) || (rom_addr == '0));

endmodule

bind bitstream_feeder bitstream_feeder_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .play_btn(play_btn), .stop_btn(stop_btn),
  .data_req(data_req), .rom_addr(rom_addr), .sdata(sdata), .sclk(sclk),
  .playing(playing), .paused(paused)
);

// File: tb/test_bitstream_feeder.sv
`timescale 1ns/100ps
module test_bitstream_feeder;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 12;
  localparam int ROMSZ  = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0, play_btn = 1'b0, stop_btn = 1'b0, data_req = 1'b1;
  logic [7:0] rom_data;
  logic [ADDR_W-1:0] rom_addr;
  logic sdata, sclk, playing, paused;

  logic [7:0] rom [ROMSZ];
  int errors = 0, checks = 0, cycles = 0;
  int exp_idx = 0, nbits = 0;
  logic [7:0] cur = 8'd0;
  logic prev_sclk = 1'b0;
  logic rand_req = 1'b0, hold_req = 1'b0;

  always #2.5 clk = ~clk;

  assign rom_data = rom[rom_addr];

  bitstream_feeder #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_bitstream_feeder (
    .clk(clk), .rst_n(rst_n), .play_btn(play_btn), .stop_btn(stop_btn),
    .data_req(data_req), .rom_data(rom_data), .rom_addr(rom_addr),
    .sdata(sdata), .sclk(sclk), .playing(playing), .paused(paused));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_byte(input int i);
    return rom[i];
  endfunction

  always @(negedge clk) begin
    if (hold_req)      data_req <= 1'b0;
    else if (rand_req) data_req <= ($urandom % 4) != 0;
    else               data_req <= 1'b1;
  end

  // decoder-side monitor: capture on sclk rising edge
  always @(posedge clk) begin
    #1;
    if (sclk && !prev_sclk) begin
      cur = {cur[6:0], sdata};
      nbits++;
      if (nbits == 8) begin
        nbits = 0;
        if (exp_idx >= DEPTH) check(1'b0, "R9 extra byte", exp_idx, DEPTH - 1);
        else check(cur == expect_byte(exp_idx), "R3 R10 byte order", cur, expect_byte(exp_idx));
        exp_idx++;
      end
    end
    prev_sclk = sclk;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic press(input bit p, input bit s, input int hold);
    @(negedge clk);
    play_btn = p; stop_btn = s;
    repeat (hold) @(negedge clk);
    play_btn = 1'b0; stop_btn = 1'b0;
  endtask

  task automatic wait_bytes(input int n);
    while (exp_idx < n) @(negedge clk);
  endtask

  task automatic clear_mon();
    exp_idx = 0; nbits = 0;
  endtask

  initial begin
    logic [ADDR_W-1:0] a0;
    logic s0;
    void'($urandom(32'd2024));
    for (int i = 0; i < ROMSZ; i++) rom[i] = 8'($urandom);
    repeat (4) @(negedge clk);
    check(!sclk && !sdata && !playing && !paused && rom_addr == 0, "R1 reset", {sclk, sdata, playing, paused}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rom_addr == 0 && !sclk, "R1 after reset", rom_addr, 0);

    press(1, 0, 1);
    check(playing == 1 && paused == 0, "R2 play from idle", playing, 1);
    wait_bytes(3);

    rand_req = 1'b1;
    wait_bytes(5);
    @(negedge clk); hold_req = 1'b1;
    repeat (3) @(negedge clk);
    a0 = rom_addr; s0 = sclk;
    repeat (15) @(negedge clk);
    check(rom_addr == a0 && sclk == s0 && playing, "R4 backpressure hold", rom_addr, a0);
    hold_req = 1'b0;

    press(1, 0, 1);
    check(paused == 1 && playing == 0, "R5 pause", paused, 1);
    a0 = rom_addr; s0 = sclk;
    repeat (30) @(negedge clk);
    check(rom_addr == a0 && sclk == s0, "R5 pause hold", rom_addr, a0);
    press(1, 0, 1);
    check(playing == 1, "R5 resume", playing, 1);

    wait_bytes(7);
    press(1, 0, 12);
    check(paused == 1, "R7 held play acts once", paused, 1);
    press(1, 0, 1);
    check(playing == 1, "R7 resume after held", playing, 1);

    wait_bytes(DEPTH);
    repeat (6) @(negedge clk);
    check(!playing && !paused && rom_addr == 0, "R9 end of stream idle", rom_addr, 0);
    check(exp_idx == DEPTH, "R9 byte count", exp_idx, DEPTH);

    clear_mon();
    press(1, 0, 1);
    wait_bytes(3);
    repeat ($urandom % 9) @(negedge clk);
    press(0, 1, 1);
    check(!playing && !paused && !sclk && rom_addr == 0, "R6 stop while streaming", rom_addr, 0);
    clear_mon();
    press(1, 0, 1);
    wait_bytes(2);
    check(exp_idx >= 2, "R6 restart from byte 0", exp_idx, 2);

    repeat (5) @(negedge clk);
    press(1, 0, 1);
    press(0, 1, 1);
    check(!playing && !paused && rom_addr == 0, "R6 stop while paused", {playing, paused}, 0);
    clear_mon();

    press(1, 0, 1);
    wait_bytes(2);
    repeat (3) @(negedge clk);
    press(1, 1, 1);
    check(!playing && !paused && rom_addr == 0, "R8 play+stop while streaming", {playing, paused}, 0);
    clear_mon();
    press(1, 1, 1);
    repeat (4) @(negedge clk);
    check(!playing && !paused && !sclk, "R8 play+stop while idle", playing, 0);
    check(exp_idx == 0, "R8 nothing sent", exp_idx, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule